// File: doc/BRIEF.md
# Coprocessor Interrupt Priority Arbiter

This block decides, once per instruction boundary of an embedded coprocessor core, whether the core must enter an interrupt and which kind. Four sources compete: a non-maskable request forced by the host, a timer request, a DMA-completion request and a maskable request forced by the host. Each source is qualified by bits in a small register file, written by the host: a control register, an enable register and an acknowledge-latch register. An acknowledge-latch register bit that is set keeps its source quiet. A separate write-one-to-clear strobe clears latch bits and so re-arms a source.

When the core signals a boundary, the arbiter picks at most one source by fixed priority. It records the choice in a sticky status register and, one cycle later, raises a one-cycle dispatch pulse with a 2-bit vector select. If the core was parked in a wait-for-interrupt state, the same dispatch leaves that state and asks the core to step its program counter past the wait instruction. Two halt/sleep bits in the control register stop instruction issue and also block dispatch.

Top module: `coproc_irq_arbiter`

## Requirements
- R1: A synchronous active-high reset clears the control, enable, acknowledge and status registers and the wait state, and holds `take`, `vec_sel` and `pc_advance` at zero. After reset `issue_en` is 1.
- R2: While control bit 5 (halt) or control bit 6 (sleep) is set, `issue_en` is 0 and no dispatch happens at a boundary.
- R3: At a boundary, if control bit 4 is set and acknowledge bit 4 is clear, the cycle after it shows `take`=1 with `vec_sel`=2'b01, and status bit 4 and acknowledge bit 4 are set. The same request is therefore not taken again.
- R4: The non-maskable check ignores `cpu_iflag` and wins over every maskable source when both are ready.
- R5: While `cpu_iflag` is 1, no maskable source is dispatched.
- R6: The maskable order is fixed: timer (enable bit 6) first, then DMA (enable bit 5), then host (control bit 7). A dispatch shows `vec_sel`=2'b10 and sets status bit 6, 5 or 7 respectively. A maskable dispatch does not touch the acknowledge register.
- R7: A maskable source whose acknowledge bit (6, 5 or 7) is set is skipped. The host loads the acknowledge register through `ack_wr`/`ack_wdata`.
- R8: No dispatch happens in a cycle without `boundary`, and `vec_sel` is 2'b00 whenever `take` is 0.
- R9: `wai_enter` sets `waiting` on the next cycle. A dispatch clears `waiting` and pulses `pc_advance` together with `take`, but only if `waiting` was set. A dispatch outside the wait state leaves `pc_advance` at 0.
- R10: The `ack_clr` strobe clears each acknowledge bit that it marks with a 1, which re-arms that source. If a clear and a non-maskable dispatch hit bit 4 in the same cycle, the bit ends set.
- R11: Register writes land at the clock edge. A boundary in the same cycle as a write is judged on the values held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control data: bit 7 host IRQ, 6 sleep, 5 halt, 4 NMI |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable data: bit 6 timer, bit 5 DMA |
| ack_wr | input | 1 | Load strobe for the acknowledge register |
| ack_wdata | input | 8 | Acknowledge load value |
| ack_clr | input | 8 | Write-one-to-clear mask for the acknowledge register |
| boundary | input | 1 | Core is at an instruction boundary |
| cpu_iflag | input | 1 | Core interrupt-disable flag |
| wai_enter | input | 1 | Core executes a wait-for-interrupt instruction |
| issue_en | output | 1 | Instruction issue allowed |
| take | output | 1 | One-cycle dispatch pulse |
| vec_sel | output | 2 | 01 non-maskable, 10 maskable, 00 idle |
| pc_advance | output | 1 | Step PC past the wait instruction |
| waiting | output | 1 | Wait-for-interrupt state |
| status | output | 8 | Sticky record of dispatched sources |
| ack | output | 8 | Acknowledge-latch register |

## Verification
Two things can fall in the same cycle: an acknowledge clear from the host and a non-maskable dispatch, both acting on latch bit 4. The bench provokes this in two ways. First it clears the bit in the same cycle as a boundary while the bit is already set: no dispatch follows and the bit ends clear. Then it issues the clear while the bit is clear and the request is ready: the dispatch goes ahead and the bit ends set. A second overlap is a wait entry and a dispatch in the same cycle. That case is judged by `waiting` reading 0 after the pulse.

// File: rtl/cia_pkg.sv
package cia_pkg;
    parameter int W = 8;
    localparam int B_HIRQ  = 7;
    localparam int B_SLEEP = 6;
    localparam int B_HALT  = 5;
    localparam int B_NMI   = 4;
    localparam int B_TMR   = 6;
    localparam int B_DMA   = 5;

    typedef enum logic [1:0] {
        VEC_NONE = 2'b00,
        VEC_NMI  = 2'b01,
        VEC_IRQ  = 2'b10
    } vec_e;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_NMI, SRC_TMR, SRC_DMA, SRC_HOST
    } src_e;
endpackage

// File: rtl/cia_regfile.sv
module cia_regfile
    import cia_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         ctl_wr,
    input  logic [W-1:0] ctl_wdata,
    input  logic         en_wr,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] ctl_q,
    output logic [W-1:0] en_q
);
    typedef struct packed {
        logic [W-1:0] ctl;
        logic [W-1:0] en;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (ctl_wr) rf_d.ctl = ctl_wdata;
        if (en_wr)  rf_d.en  = en_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) rf_q <= '0;
        else     rf_q <= rf_d;
    end

    assign ctl_q = rf_q.ctl;
    assign en_q  = rf_q.en;
endmodule

// File: rtl/cia_pick.sv
module cia_pick
    import cia_pkg::*;
(
    input  logic [W-1:0] ctl,
    input  logic [W-1:0] en,
    input  logic [W-1:0] ackl,
    input  logic         iflag,
    input  logic         boundary,
    output src_e         src
);
    logic gated;
    logic nmi_rdy, tmr_rdy, dma_rdy, host_rdy;

    always_comb begin
        gated    = ctl[B_HALT] | ctl[B_SLEEP];
        nmi_rdy  = ctl[B_NMI]  & ~ackl[B_NMI];
        tmr_rdy  = en[B_TMR]   & ~ackl[B_TMR];
        dma_rdy  = en[B_DMA]   & ~ackl[B_DMA];
        host_rdy = ctl[B_HIRQ] & ~ackl[B_HIRQ];
        src = SRC_NONE;
        if (boundary && !gated) begin
            if (nmi_rdy)         src = SRC_NMI;
            else if (!iflag) begin
                if (tmr_rdy)       src = SRC_TMR;
                else if (dma_rdy)  src = SRC_DMA;
                else if (host_rdy) src = SRC_HOST;
            end
        end
    end
endmodule

// File: rtl/coproc_irq_arbiter.sv
module coproc_irq_arbiter
    import cia_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         ctl_wr,
    input  logic [W-1:0] ctl_wdata,
    input  logic         en_wr,
    input  logic [W-1:0] en_wdata,
    input  logic         ack_wr,
    input  logic [W-1:0] ack_wdata,
    input  logic [W-1:0] ack_clr,
    input  logic         boundary,
    input  logic         cpu_iflag,
    input  logic         wai_enter,
    output logic         issue_en,
    output logic         take,
    output logic [1:0]   vec_sel,
    output logic         pc_advance,
    output logic         waiting,
    output logic [W-1:0] status,
    output logic [W-1:0] ack
);
    typedef struct packed {
        logic [W-1:0] status;
        logic [W-1:0] ackl;
        logic         wait_st;
        logic         take;
        vec_e         vec;
        logic         pcadv;
    } st_t;

    st_t  st_d, st_q;
    logic [W-1:0] ctl_q, en_q;
    src_e src;

    cia_regfile u_rf (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .ctl_q(ctl_q), .en_q(en_q)
    );

    cia_pick u_pick (
        .ctl(ctl_q), .en(en_q), .ackl(st_q.ackl),
        .iflag(cpu_iflag), .boundary(boundary), .src(src)
    );

    always_comb begin
        st_d       = st_q;
        st_d.take  = (src != SRC_NONE);
        st_d.vec   = VEC_NONE;
        st_d.pcadv = 1'b0;
        if (ack_wr) st_d.ackl = ack_wdata;
        st_d.ackl = st_d.ackl & ~ack_clr;
        if (wai_enter) st_d.wait_st = 1'b1;
        case (src)
            SRC_NMI: begin
                st_d.vec           = VEC_NMI;
                st_d.status[B_NMI] = 1'b1;
                st_d.ackl[B_NMI]   = 1'b1;
            end
            SRC_TMR: begin
                st_d.vec           = VEC_IRQ;
                st_d.status[B_TMR] = 1'b1;
            end
            SRC_DMA: begin
                st_d.vec           = VEC_IRQ;
                st_d.status[B_DMA] = 1'b1;
            end
            SRC_HOST: begin
                st_d.vec            = VEC_IRQ;
                st_d.status[B_HIRQ] = 1'b1;
            end
            default: ;
        endcase
        if (st_d.take) begin
            st_d.pcadv   = st_q.wait_st;
            st_d.wait_st = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign issue_en   = ~(ctl_q[B_HALT] | ctl_q[B_SLEEP]);
    assign take       = st_q.take;
    assign vec_sel    = st_q.vec;
    assign pc_advance = st_q.pcadv;
    assign waiting    = st_q.wait_st;
    assign status     = st_q.status;
    assign ack        = st_q.ackl;
endmodule

// File: rtl/coproc_irq_arbiter_chk.sv
module coproc_irq_arbiter_chk
    import cia_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] ctl_q,
    input logic         boundary,
    input logic         cpu_iflag,
    input logic         take,
    input logic [1:0]   vec_sel,
    input logic         pc_advance,
    input logic         waiting,
    input logic [W-1:0] status,
    input logic [W-1:0] ack
);
    logic nmi_ready;
    assign nmi_ready = ctl_q[B_NMI] & ~ack[B_NMI];

    assert_halt_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[B_HALT] || ctl_q[B_SLEEP]) |=> !take);

    assert_nmi_marks_R3: assert property (@(posedge clk) disable iff (rst)
        (take && vec_sel == VEC_NMI) |-> (ack[B_NMI] && status[B_NMI]));

    assert_iflag_masks_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_iflag && !nmi_ready) |=> !take);

    assert_no_boundary_R8: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> !take);

    assert_vec_idle_R8: assert property (@(posedge clk) disable iff (rst)
        take == (vec_sel != VEC_NONE));

    assert_wait_left_R9: assert property (@(posedge clk) disable iff (rst)
        take |-> !waiting);

    assert_pcadv_with_take_R9: assert property (@(posedge clk) disable iff (rst)
        pc_advance |-> (take && $past(waiting)));
endmodule

bind coproc_irq_arbiter coproc_irq_arbiter_chk u_chk (
    .clk(clk), .rst(rst), .ctl_q(ctl_q), .boundary(boundary),
    .cpu_iflag(cpu_iflag), .take(take), .vec_sel(vec_sel),
    .pc_advance(pc_advance), .waiting(waiting), .status(status), .ack(ack)
);

// File: tb/test_coproc_irq_arbiter.sv
module test_coproc_irq_arbiter;
    logic clk = 1'b0;
    logic rst;
    logic ctl_wr, en_wr, ack_wr, boundary, cpu_iflag, wai_enter;
    logic [7:0] ctl_wdata, en_wdata, ack_wdata, ack_clr;
    logic issue_en, take, pc_advance, waiting;
    logic [1:0] vec_sel;
    logic [7:0] status, ack;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    coproc_irq_arbiter i_coproc_irq_arbiter (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .ack_wr(ack_wr), .ack_wdata(ack_wdata), .ack_clr(ack_clr),
        .boundary(boundary), .cpu_iflag(cpu_iflag), .wai_enter(wai_enter),
        .issue_en(issue_en), .take(take), .vec_sel(vec_sel),
        .pc_advance(pc_advance), .waiting(waiting),
        .status(status), .ack(ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        ctl_wr = 0; en_wr = 0; ack_wr = 0; boundary = 0; wai_enter = 0;
        ack_clr = 8'h00;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk); idle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle(); cpu_iflag = 0; ctl_wdata = 0; en_wdata = 0; ack_wdata = 0;
        rst = 1; step(); step(); rst = 0;
    endtask

    task automatic wr_ctl(input logic [7:0] v); ctl_wr = 1; ctl_wdata = v; step(); endtask
    task automatic wr_en(input logic [7:0] v);  en_wr = 1;  en_wdata = v;  step(); endtask
    task automatic wr_ack(input logic [7:0] v); ack_wr = 1; ack_wdata = v; step(); endtask
    task automatic bnd(); boundary = 1; step(); endtask

    task automatic t_reset();
        do_reset();
        chk("R1 status", status, 8'h00);
        chk("R1 ack", ack, 8'h00);
        chk("R1 waiting", waiting, 0);
        chk("R1 take", take, 0);
        chk("R1 vec", vec_sel, 2'b00);
        chk("R1 issue_en", issue_en, 1);
    endtask

    task automatic t_halt();
        do_reset();
        wr_ctl(8'h30);
        chk("R2 issue halt", issue_en, 0);
        bnd();
        chk("R2 no take halt", take, 0);
        wr_ctl(8'h50);
        chk("R2 issue sleep", issue_en, 0);
        bnd();
        chk("R2 no take sleep", take, 0);
        chk("R2 status", status, 8'h00);
        wr_ctl(8'h10);
        chk("R2 issue back", issue_en, 1);
        bnd();
        chk("R3 take", take, 1);
        chk("R3 vec", vec_sel, 2'b01);
        chk("R3 status", status, 8'h10);
        chk("R3 ack", ack, 8'h10);
        bnd();
        chk("R3 once", take, 0);
    endtask

    task automatic t_nmi_first();
        do_reset();
        wr_en(8'h60); wr_ctl(8'h90);
        cpu_iflag = 1;
        bnd();
        chk("R4 take", take, 1);
        chk("R4 vec", vec_sel, 2'b01);
        chk("R4 status", status, 8'h10);
        cpu_iflag = 0;
    endtask

    task automatic t_iflag();
        do_reset();
        wr_en(8'h40);
        cpu_iflag = 1;
        bnd();
        chk("R5 masked", take, 0);
        cpu_iflag = 0;
        bnd();
        chk("R5 unmasked take", take, 1);
        chk("R6 vec", vec_sel, 2'b10);
        chk("R6 timer status", status, 8'h40);
    endtask

    task automatic t_priority();
        do_reset();
        wr_en(8'h60); wr_ctl(8'h80);
        bnd();
        chk("R6 timer first", status, 8'h40);
        chk("R6 ack untouched", ack, 8'h00);
        wr_ack(8'h40);
        bnd();
        chk("R7 dma next", status, 8'h60);
        chk("R7 take", take, 1);
        wr_ack(8'h60);
        bnd();
        chk("R7 host last", status, 8'he0);
        chk("R6 host vec", vec_sel, 2'b10);
        wr_ack(8'he0);
        bnd();
        chk("R7 all acked", take, 0);
    endtask

    task automatic t_boundary();
        do_reset();
        wr_ctl(8'h10);
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R8 no boundary", take, 0);
            chk("R8 vec idle", vec_sel, 2'b00);
        end
        // R11: write and boundary in one cycle use old control value
        ctl_wr = 1; ctl_wdata = 8'h30; boundary = 1; step();
        chk("R11 old value used", take, 1);
    endtask

    task automatic t_wait();
        do_reset();
        wai_enter = 1; step();
        chk("R9 waiting set", waiting, 1);
        wr_ctl(8'h80);
        bnd();
        chk("R9 take", take, 1);
        chk("R9 pc_advance", pc_advance, 1);
        chk("R9 wait cleared", waiting, 0);
        bnd();
        chk("R9 no pc_advance", pc_advance, 0);
        chk("R9 take again", take, 1);
        wai_enter = 1; boundary = 1; step();
        chk("R9 same-cycle waiting", waiting, 0);
    endtask

    task automatic t_ackclr();
        do_reset();
        wr_ctl(8'h10);
        bnd();
        chk("R10 ack set", ack, 8'h10);
        ack_clr = 8'h10; step();
        chk("R10 cleared", ack, 8'h00);
        bnd();
        chk("R10 rearmed", take, 1);
        ack_clr = 8'h10; boundary = 1; step();
        chk("R10 no take while latched", take, 0);
        chk("R10 clear wins", ack, 8'h00);
        ack_clr = 8'h10; boundary = 1; step();
        chk("R10 take", take, 1);
        chk("R10 set wins", ack, 8'h10);
    endtask

    initial begin
        rst = 1; cpu_iflag = 0; idle();
        ctl_wdata = 0; en_wdata = 0; ack_wdata = 0;
        t_reset();
        t_halt();
        t_nmi_first();
        t_iflag();
        t_priority();
        t_boundary();
        t_wait();
        t_ackclr();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule